// File: doc/BRIEF.md
# PLL Lock Detector with Watchdog

This block reports whether a phase-locked loop has locked. It takes the reference and feedback clocks of the loop as plain level inputs and samples them in a fast system clock domain. It pairs each feedback rising edge with the nearest reference rising edge. A feedback cycle counts as good when the two edges lie within a programmable window of sampling cycles, in either order. Otherwise the cycle counts as a phase error.

The lock flag has asymmetric hysteresis. It rises only after a long unbroken run of good feedback cycles, and it falls after a short unbroken run of erroring cycles. A stopped feedback clock produces no feedback cycles, so phase errors alone cannot clear the flag. For that case a watchdog counts ticks of a divided-down reference clock, restarts on every feedback edge, and drops the lock when it expires. The reference clock has to keep running for the indication to be meaningful.

Top module: `pll_lock_det`

## Requirements
- R1: During and right after reset, `lock_o` is low and all run and timeout counters are cleared.
- R2: A feedback rising edge is good when a reference rising edge lies at most `win_i` sampling cycles before it, or follows it within `win_i` sampling cycles. Edges that reach the pins in the same sampling cycle are 0 cycles apart. Any other feedback edge is a phase error. When the feedback edge leads the reference edge, the verdict is given at the reference edge or once `win_i` cycles have passed.
- R3: While unlocked, `lock_o` rises after 32 consecutive good feedback cycles. The rise comes three sampling edges after the 32nd feedback rising edge reaches the pin, in the lagging or coincident case.
- R4: While unlocked, a phase error clears the good run, so another full 32 good cycles are needed.
- R5: While locked, `lock_o` falls after 4 consecutive phase-error feedback cycles, and stays high after 3.
- R6: While locked, a good feedback cycle clears the error run.
- R7: With `wd_div_i` = D, the watchdog ticks once every D+1 reference rising edges. After 8 ticks with no feedback rising edge, `lock_o` is forced low and the good run is cleared.
- R8: Each feedback rising edge restarts the watchdog count. A feedback clock at the reference rate therefore never lets the watchdog drop the lock, however long the run.
- R9: With `win_i` = 0, only feedback and reference edges that reach the pins in the same sampling cycle count as good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_clk_i | input | 1 | Reference clock level, asynchronous |
| fb_clk_i | input | 1 | Feedback clock level, asynchronous |
| win_i | input | WIN_W (4) | Allowed edge distance in sampling cycles |
| wd_div_i | input | DIV_W (4) | Watchdog tick divides reference edges by this value plus one |
| lock_o | output | 1 | Lock indication |

## Verification
A rising edge driven on either clock pin gives an internal edge pulse after two sampling edges. The lock flag is registered on the third edge. The bench drives its inputs on the falling edge and checks the 32nd-edge rise of R3 in exactly that cycle: low after the second edge, high after the third. All other checks, on hysteresis runs, windows in both directions and watchdog expiry, are sampled at the end of a 16-cycle reference period. By then every verdict of that period, including a leading-edge verdict that waits up to `win_i` cycles, has settled with several cycles to spare. The watchdog checks use counts of reference edges with one tick of margin on each side, which covers the unknown phase of the divider when the feedback clock stops.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  typedef enum logic {
    LK_OFF = 1'b0,
    LK_ON  = 1'b1
  } lock_st_e;
endpackage

// File: rtl/pll_edge_sync.sv
module pll_edge_sync #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= lvl_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign rise_o[g] = s2_q & ~s3_q;
  end
endmodule

// File: rtl/pll_phase_cmp.sv
module pll_phase_cmp #(
  parameter int WIN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_rise_i,
  input  logic             fb_rise_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             good_o,
  output logic             err_o
);
  localparam int AGE_W = WIN_W + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [AGE_W-1:0] age_q, diff, k, win_x;
  logic             pend_q, pend_d;
  logic [WIN_W-1:0] pcnt_q, pcnt_d;

  assign win_x = {1'b0, win_i};

  // age_q saturates: "no recent reference edge" reads as too far
  always_comb begin
    diff   = ref_rise_i ? '0 : ((age_q == AGE_MAX) ? AGE_MAX : age_q + AGE_W'(1));
    k      = {1'b0, pcnt_q} + AGE_W'(1);
    good_o = 1'b0;
    err_o  = 1'b0;
    pend_d = pend_q;
    pcnt_d = pcnt_q;
    if (fb_rise_i) begin
      pend_d = 1'b0;
      pcnt_d = '0;
      if (diff <= win_x)      good_o = 1'b1;
      else if (win_i == '0)   err_o  = 1'b1;
      else                    pend_d = 1'b1;  // wait for a trailing reference edge
    end else if (pend_q) begin
      if (ref_rise_i) begin
        good_o = 1'b1;
        pend_d = 1'b0;
      end else if (k >= win_x) begin
        err_o  = 1'b1;
        pend_d = 1'b0;
      end else begin
        pcnt_d = pcnt_q + WIN_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q  <= AGE_MAX;
      pend_q <= 1'b0;
      pcnt_q <= '0;
    end else begin
      pend_q <= pend_d;
      pcnt_q <= pcnt_d;
      if (ref_rise_i)            age_q <= '0;
      else if (age_q != AGE_MAX) age_q <= age_q + AGE_W'(1);
    end
  end
endmodule

// File: rtl/pll_wd_timer.sv
module pll_wd_timer #(
  parameter int DIV_W    = 4,
  parameter int WD_LIMIT = 8,
  parameter int WD_W     = $clog2(WD_LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_rise_i,
  input  logic             fb_rise_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             expire_o,
  output logic [WD_W-1:0]  cnt_o
);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(WD_LIMIT - 1);

  logic [DIV_W-1:0] pre_q;
  logic [WD_W-1:0]  cnt_q;
  logic             tick;

  assign tick     = ref_rise_i && (pre_q == div_i);
  assign expire_o = tick && !fb_rise_i && (cnt_q == WD_LAST);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      if (ref_rise_i) pre_q <= tick ? '0 : pre_q + DIV_W'(1);
      if (fb_rise_i)  cnt_q <= '0;
      else if (tick)  cnt_q <= expire_o ? '0 : cnt_q + WD_W'(1);
    end
  end
endmodule

// File: rtl/pll_lock_fsm.sv
module pll_lock_fsm
  import pll_lock_pkg::*;
#(
  parameter int GOOD_N = 32,
  parameter int BAD_N  = 4,
  parameter int GW     = $clog2(GOOD_N + 1),
  parameter int BW     = $clog2(BAD_N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          good_i,
  input  logic          err_i,
  input  logic          expire_i,
  output logic          lock_o,
  output logic [GW-1:0] good_cnt_o,
  output logic [BW-1:0] bad_cnt_o
);
  localparam logic [GW-1:0] G_LAST = GW'(GOOD_N - 1);
  localparam logic [BW-1:0] B_LAST = BW'(BAD_N - 1);

  lock_st_e      st_q;
  logic [GW-1:0] gc_q;
  logic [BW-1:0] bc_q;

  assign lock_o     = (st_q == LK_ON);
  assign good_cnt_o = gc_q;
  assign bad_cnt_o  = bc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= LK_OFF;
      gc_q <= '0;
      bc_q <= '0;
    end else if (expire_i) begin
      st_q <= LK_OFF;
      gc_q <= '0;
      bc_q <= '0;
    end else if (good_i) begin
      bc_q <= '0;
      if (st_q == LK_OFF) begin
        if (gc_q == G_LAST) begin
          st_q <= LK_ON;
          gc_q <= '0;
        end else begin
          gc_q <= gc_q + GW'(1);
        end
      end
    end else if (err_i) begin
      gc_q <= '0;
      if (st_q == LK_ON) begin
        if (bc_q == B_LAST) begin
          st_q <= LK_OFF;
          bc_q <= '0;
        end else begin
          bc_q <= bc_q + BW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pll_lock_det.sv
module pll_lock_det #(
  parameter int WIN_W    = 4,
  parameter int DIV_W    = 4,
  parameter int GOOD_N   = 32,
  parameter int BAD_N    = 4,
  parameter int WD_LIMIT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_clk_i,
  input  logic             fb_clk_i,
  input  logic [WIN_W-1:0] win_i,
  input  logic [DIV_W-1:0] wd_div_i,
  output logic             lock_o
);
  localparam int GW   = $clog2(GOOD_N + 1);
  localparam int BW   = $clog2(BAD_N + 1);
  localparam int WD_W = $clog2(WD_LIMIT + 1);

  logic [1:0]      rise;
  logic            ref_edge, fb_edge, good_ev, err_ev, wd_expire;
  logic [GW-1:0]   good_cnt;
  logic [BW-1:0]   bad_cnt;
  logic [WD_W-1:0] wd_cnt;

  assign ref_edge = rise[0];
  assign fb_edge  = rise[1];

  pll_edge_sync #(.N(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i ({fb_clk_i, ref_clk_i}),
    .rise_o(rise)
  );

  pll_phase_cmp #(.WIN_W(WIN_W)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_rise_i(ref_edge),
    .fb_rise_i (fb_edge),
    .win_i     (win_i),
    .good_o    (good_ev),
    .err_o     (err_ev)
  );

  pll_wd_timer #(.DIV_W(DIV_W), .WD_LIMIT(WD_LIMIT), .WD_W(WD_W)) u_wd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_rise_i(ref_edge),
    .fb_rise_i (fb_edge),
    .div_i     (wd_div_i),
    .expire_o  (wd_expire),
    .cnt_o     (wd_cnt)
  );

  pll_lock_fsm #(.GOOD_N(GOOD_N), .BAD_N(BAD_N), .GW(GW), .BW(BW)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .good_i    (good_ev),
    .err_i     (err_ev),
    .expire_i  (wd_expire),
    .lock_o    (lock_o),
    .good_cnt_o(good_cnt),
    .bad_cnt_o (bad_cnt)
  );
endmodule

// File: rtl/pll_lock_det_chk.sv
module pll_lock_det_chk #(
  parameter int GOOD_N = 32,
  parameter int BAD_N  = 4,
  parameter int GW     = 6,
  parameter int BW     = 3,
  parameter int WD_W   = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            lock_o,
  input logic            good_ev,
  input logic            err_ev,
  input logic            wd_expire,
  input logic            fb_edge,
  input logic [GW-1:0]   good_cnt,
  input logic [BW-1:0]   bad_cnt,
  input logic [WD_W-1:0] wd_cnt
);
  AST_RISE_AFTER_GOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(good_ev)); // R3
  AST_GOOD_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_cnt < GW'(GOOD_N)); // R3
  AST_ERR_CLEARS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_ev && !good_ev && !lock_o) |=> (good_cnt == '0)); // R4
  AST_FALL_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> $past(err_ev || wd_expire)); // R5
  AST_BAD_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_cnt < BW'(BAD_N)); // R5
  AST_GOOD_CLEARS_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_ev |=> (bad_cnt == '0)); // R6
  AST_ONE_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(good_ev && err_ev)); // R2
  AST_EXPIRE_UNLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_expire |=> !lock_o); // R7
  AST_FB_RESTARTS_WD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_edge |=> (wd_cnt == '0)); // R8
endmodule

bind pll_lock_det pll_lock_det_chk #(
  .GOOD_N(GOOD_N), .BAD_N(BAD_N), .GW(GW), .BW(BW), .WD_W(WD_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .lock_o   (lock_o),
  .good_ev  (good_ev),
  .err_ev   (err_ev),
  .wd_expire(wd_expire),
  .fb_edge  (fb_edge),
  .good_cnt (good_cnt),
  .bad_cnt  (bad_cnt),
  .wd_cnt   (wd_cnt)
);

// File: tb/tb_pll_lock_det.sv
`timescale 1ns/1ps
module tb_pll_lock_det;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ref_clk_i = 1'b0;
  logic       fb_clk_i = 1'b0;
  logic [3:0] win_i = 4'd2;
  logic [3:0] wd_div_i = 4'd0;
  logic       lock_o;

  int n_chk = 0;
  int n_bad = 0;
  int gt = 0;
  int ofs = 1;
  bit fb_en = 1'b1;
  bit done = 1'b0;

  pll_lock_det dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_clk_i(ref_clk_i), .fb_clk_i(fb_clk_i),
    .win_i(win_i), .wd_div_i(wd_div_i), .lock_o(lock_o)
  );

  always #2 clk_i = ~clk_i;

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s lock_o actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // one sampling cycle: drive at falling edge, return at next falling edge
  task automatic step();
    ref_clk_i = ((gt % 16) < 8);
    fb_clk_i  = fb_en && (((gt + 64 - ofs) % 16) < 8);
    gt++;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic periods(input int n);
    repeat (n * 16) step();
  endtask

  task automatic do_reset(input logic [3:0] w, input logic [3:0] d, input int o);
    rst_ni = 1'b0; ref_clk_i = 1'b0; fb_clk_i = 1'b0;
    win_i = w; wd_div_i = d; ofs = o; fb_en = 1'b1; gt = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(lock_o, 1'b0, "R1 in reset");
    do_reset(4'd2, 4'd0, 1);
    step();
    chk(lock_o, 1'b0, "R1 after reset");
  endtask

  task automatic t_lock_timing();
    do_reset(4'd2, 4'd0, 1);
    periods(31);
    chk(lock_o, 1'b0, "R3 after 31 good");
    step(); step();               // second step drives the 32nd feedback rise
    step();
    chk(lock_o, 1'b0, "R3 two edges after 32nd");
    step();
    chk(lock_o, 1'b1, "R3 three edges after 32nd");
  endtask

  task automatic t_window();
    do_reset(4'd3, 4'd0, -3);
    periods(40);
    chk(lock_o, 1'b1, "R2 lead 3 win 3");
    do_reset(4'd2, 4'd0, -3);
    periods(40);
    chk(lock_o, 1'b0, "R2 lead 3 win 2");
    do_reset(4'd2, 4'd0, 3);
    periods(40);
    chk(lock_o, 1'b0, "R2 lag 3 win 2");
    do_reset(4'd2, 4'd0, 2);
    periods(40);
    chk(lock_o, 1'b1, "R2 lag 2 win 2");
  endtask

  task automatic t_window_zero();
    do_reset(4'd0, 4'd0, 0);
    periods(40);
    chk(lock_o, 1'b1, "R9 coincident win 0");
    do_reset(4'd0, 4'd0, 1);
    periods(40);
    chk(lock_o, 1'b0, "R9 lag 1 win 0");
  endtask

  task automatic t_err_restarts();
    do_reset(4'd2, 4'd0, 1);
    periods(31);
    ofs = 5; periods(1);
    ofs = 1; periods(31);
    chk(lock_o, 1'b0, "R4 31 after error");
    periods(1);
    chk(lock_o, 1'b1, "R4 32 after error");
  endtask

  task automatic t_hysteresis();
    do_reset(4'd2, 4'd0, 1);
    periods(33);
    chk(lock_o, 1'b1, "R5 locked first");
    ofs = 5; periods(3);
    chk(lock_o, 1'b1, "R5 three errors keep lock");
    ofs = 1; periods(1);
    ofs = 5; periods(3);
    chk(lock_o, 1'b1, "R6 good cycle clears error run");
    periods(1);
    chk(lock_o, 1'b0, "R5 fourth error drops lock");
  endtask

  task automatic t_watchdog();
    do_reset(4'd2, 4'd0, 1);
    periods(40);
    chk(lock_o, 1'b1, "R8 running feedback keeps lock");
    fb_en = 1'b0;
    periods(7);
    chk(lock_o, 1'b1, "R7 div0 seven ticks");
    periods(2);
    chk(lock_o, 1'b0, "R7 div0 expired");
    do_reset(4'd2, 4'd1, 1);
    periods(33);
    chk(lock_o, 1'b1, "R8 div1 locked");
    fb_en = 1'b0;
    periods(13);
    chk(lock_o, 1'b1, "R7 div1 before timeout");
    periods(4);
    chk(lock_o, 1'b0, "R7 div1 expired");
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_lock_timing();
    t_window();
    t_window_zero();
    t_err_restarts();
    t_hysteresis();
    t_watchdog();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule